// File: doc/BRIEF.md
# Event-Gated Fractional Rate Divider

This block paces the counter of a pulse-width modulation channel. Every system clock it decides whether an input event occurred, and it runs those events through a fractional divider. The divider produces one-cycle count-enable strobes at the event rate divided by a fixed-point divisor. The divisor has an 8-bit whole part and a 4-bit sixteenths part.

A 2-bit source selector chooses what counts as an event:
- every clock (free-running pacing);
- each clock on which the external `b_in` pin is high;
- each rising transition of `b_in`;
- each falling transition of `b_in`.

The pin-driven modes let the same counter measure the frequency or the high time of an outside signal. `b_in` is asynchronous, so a synchroniser and an edge detector sit in front of the selector. The counter and any register access are outside this block.

Top module: `pace_divider`

## Requirements
- R1: After reset `strobe` is low and the divider's remainder is zero, so with divisor 1.5 the first enabled event yields no strobe and the second does.
- R2: With `src_sel` = 0 (free-running) and divisor 1.0 (`div_whole`=1, `div_sixteenths`=0), `strobe` is high on every cycle while `run` is high.
- R3: For a constant divisor D given in sixteenths (D = 16*`div_whole` + `div_sixteenths`), the number of strobes after n events counted from reset is floor(16n/D). For example, D = 1.5 gives the strobe pattern 0,1,1 repeating.
- R4: A divisor whose whole part is 0 acts as 256.0 and its sixteenths part is ignored: one strobe per 256 events.
- R5: With `src_sel` = 1, an event is each clock on which the synchronised `b_in` is high.
- R6: With `src_sel` = 2, an event is each low-to-high transition of the synchronised `b_in`, one event per transition.
- R7: With `src_sel` = 3, an event is each high-to-low transition of the synchronised `b_in`, one event per transition.
- R8: While `run` is low no strobe is issued and the remainder is held. When `run` returns, counting resumes from the held remainder.
- R9: `b_in` passes through a two-stage synchroniser. A rising transition of `b_in` sampled at clock edge k produces its strobe (divisor 1.0, `src_sel` = 2) in the cycle after edge k+2, and for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable; low freezes the divider |
| src_sel | input | 2 | Event source: 0 every clock, 1 pin level, 2 pin rise, 3 pin fall |
| div_whole | input | 8 | Integer part of the divisor; 0 means 256 |
| div_sixteenths | input | 4 | Fraction part of the divisor in sixteenths |
| b_in | input | 1 | Asynchronous external pin |
| strobe | output | 1 | One-cycle count enable to the channel counter |

## Verification
In free-running mode, a `run` or divisor value held across clock edge k shows up on `strobe` in the cycle after edge k, because the strobe is registered. A pin change that lands before edge k needs two synchroniser stages and the strobe register, so it shows up only after edge k+2. The bench drives every input on the falling clock edge and samples `strobe` on the next falling edge, one cycle at a time. It counts strobes over whole stimulus windows that include these delays. The latency test checks the exact cycle one edge at a time. Before each scenario the bench resets the block, so that remainder counts start from zero.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    typedef enum logic [1:0] {
        SRC_FREE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_RISE  = 2'd2,
        SRC_FALL  = 2'd3
    } src_mode_e;

endpackage

// File: rtl/pdiv_pin_sync.sv
module pdiv_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_level,
    output logic pin_rise,
    output logic pin_fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic              armed;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_async};
        st_d.prev  = st_q.chain[STAGES-1];
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_level = st_q.chain[STAGES-1];
    assign pin_rise  = st_q.chain[STAGES-1] & ~st_q.prev;
    assign pin_fall  = ~st_q.chain[STAGES-1] & st_q.prev;

    // R9: first stage follows the pin one edge later
    assert_first_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> (st_q.chain[0] == $past(pin_async)));

    // R6/R7: a transition pulse never lasts two cycles
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);
    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall |=> !pin_fall);
endmodule

// File: rtl/pdiv_evt_sel.sv
module pdiv_evt_sel
    import pdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       pin_level,
    input  logic       pin_rise,
    input  logic       pin_fall,
    output logic       evt
);
    src_mode_e mode;

    always_comb begin
        mode = src_mode_e'(src_sel);
        unique case (mode)
            SRC_FREE:  evt = 1'b1;
            SRC_LEVEL: evt = pin_level;
            SRC_RISE:  evt = pin_rise;
            SRC_FALL:  evt = pin_fall;
            default:   evt = 1'b0;
        endcase
    end

    // R6: in rise mode an event is never followed directly by another
    assert_rise_evt_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_RISE && evt && src_sel == $past(src_sel)) |=> (src_sel != 2'd2 || !evt));

    // R5: level mode never produces an event while the pin is low
    assert_level_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_LEVEL && !pin_level) |-> !evt);
endmodule

// File: rtl/pdiv_accum.sv
module pdiv_accum #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              evt,
    input  logic [INT_W-1:0]  div_whole,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              strobe
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP    = ACC_W'(1) << FRAC_W;
    localparam logic [ACC_W-1:0] DIV_MAX = ACC_W'(1) << DIV_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             strobe;
    } acc_s;

    acc_s st_d, st_q;
    logic [ACC_W-1:0] div_eff;
    logic [ACC_W-1:0] sum;

    always_comb begin
        div_eff = (div_whole == '0) ? DIV_MAX : {1'b0, div_whole, div_frac};
        sum     = st_q.acc + STEP;
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (run && evt) begin
            if (sum >= div_eff) begin
                st_d.acc    = sum - div_eff;
                st_d.strobe = 1'b1;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;

    // R3: the remainder stays below the largest divisor
    assert_acc_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < DIV_MAX);

    // R8: a stopped channel keeps its remainder and stays quiet
    assert_hold_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(st_q.acc) && !strobe));

    // R3: without an event nothing is issued
    assert_no_evt_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !strobe);
endmodule

// File: rtl/pace_divider.sv
module pace_divider
    import pdiv_pkg::*;
#(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        src_sel,
    input  logic [INT_W-1:0]  div_whole,
    input  logic [FRAC_W-1:0] div_sixteenths,
    input  logic              b_in,
    output logic              strobe
);
    logic pin_level, pin_rise, pin_fall;
    logic evt;

    pdiv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (b_in),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall)
    );

    pdiv_evt_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall),
        .evt       (evt)
    );

    pdiv_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .evt       (evt),
        .div_whole (div_whole),
        .div_frac  (div_sixteenths),
        .strobe    (strobe)
    );

    // R2: unity divisor in free-running mode strobes every cycle
    assert_unity_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src_sel == 2'd0 && div_whole == INT_W'(1) && div_sixteenths == '0) |=> strobe);

    // R8: disabled channel issues no strobe
    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !strobe);
endmodule

// File: tb/pace_divider_tb.sv
module pace_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] div_whole = 8'd1;
    logic [3:0] div_sixteenths = 4'd0;
    logic       b_in = 1'b0;
    logic       strobe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pace_divider u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
        .div_whole(div_whole), .div_sixteenths(div_sixteenths),
        .b_in(b_in), .strobe(strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; b_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic b, inout int cnt);
        b_in = b;
        @(posedge clk);
        @(negedge clk);
        if (strobe) cnt++;
    endtask

    task automatic t_reset();
        int cnt = 0;
        do_reset();
        check(strobe == 1'b0, "R1 reset strobe", strobe, 0);
        src_sel = 2'd0; div_whole = 8'd1; div_sixteenths = 4'd8;
        run = 1'b1;
        step(1'b0, cnt);
        check(cnt == 0, "R1 first event silent", cnt, 0);
        step(1'b0, cnt);
        check(cnt == 1, "R1 second event strobes", cnt, 1);
        run = 1'b0;
    endtask

    task automatic t_unity();
        int cnt = 0;
        do_reset();
        src_sel = 2'd0; div_whole = 8'd1; div_sixteenths = 4'd0;
        run = 1'b1;
        for (int i = 0; i < 20; i++) step(1'b0, cnt);
        check(cnt == 20, "R2 unity free-running", cnt, 20);
        run = 1'b0;
    endtask

    task automatic t_fraction();
        int cnt = 0;
        int pat = 0;
        do_reset();
        src_sel = 2'd0; div_whole = 8'd1; div_sixteenths = 4'd8;
        run = 1'b1;
        for (int i = 0; i < 6; i++) begin
            int c1 = 0;
            step(1'b0, c1);
            pat = (pat << 1) | c1;
            cnt += c1;
        end
        check(pat == 6'b011011, "R3 pattern 1.5", pat, 6'b011011);
        for (int i = 0; i < 24; i++) step(1'b0, cnt);
        check(cnt == 20, "R3 count 1.5 over 30", cnt, 20);
        run = 1'b0;
        do_reset();
        cnt = 0;
        div_whole = 8'd2; div_sixteenths = 4'd4;
        run = 1'b1;
        for (int i = 0; i < 36; i++) step(1'b0, cnt);
        check(cnt == 16, "R3 count 2.25 over 36", cnt, 16);
        run = 1'b0;
    endtask

    task automatic t_zero_whole();
        int cnt = 0;
        do_reset();
        src_sel = 2'd0; div_whole = 8'd0; div_sixteenths = 4'd5;
        run = 1'b1;
        for (int i = 0; i < 255; i++) step(1'b0, cnt);
        check(cnt == 0, "R4 none before 256", cnt, 0);
        step(1'b0, cnt);
        check(cnt == 1, "R4 strobe at 256", cnt, 1);
        for (int i = 0; i < 256; i++) step(1'b0, cnt);
        check(cnt == 2, "R4 two per 512", cnt, 2);
        run = 1'b0;
    endtask

    task automatic t_level();
        int cnt = 0;
        do_reset();
        src_sel = 2'd1; div_whole = 8'd1; div_sixteenths = 4'd0;
        run = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, cnt);
        check(cnt == 0, "R5 low pin no strobe", cnt, 0);
        for (int i = 0; i < 10; i++) step(1'b1, cnt);
        for (int i = 0; i < 10; i++) step(1'b0, cnt);
        check(cnt == 10, "R5 level gated count", cnt, 10);
        run = 1'b0;
    endtask

    task automatic t_rise();
        int cnt = 0;
        do_reset();
        src_sel = 2'd2; div_whole = 8'd1; div_sixteenths = 4'd0;
        run = 1'b1;
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < 3; i++) step(1'b1, cnt);
            for (int i = 0; i < 3; i++) step(1'b0, cnt);
        end
        for (int i = 0; i < 4; i++) step(1'b0, cnt);
        check(cnt == 5, "R6 rises at 1.0", cnt, 5);
        run = 1'b0;
        do_reset();
        cnt = 0;
        div_whole = 8'd2;
        run = 1'b1;
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 2; i++) step(1'b1, cnt);
            for (int i = 0; i < 4; i++) step(1'b0, cnt);
        end
        for (int i = 0; i < 4; i++) step(1'b0, cnt);
        check(cnt == 3, "R6 rises at 2.0", cnt, 3);
        run = 1'b0;
    endtask

    task automatic t_fall();
        int cnt = 0;
        do_reset();
        src_sel = 2'd3; div_whole = 8'd1; div_sixteenths = 4'd0;
        run = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, cnt);
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 5; i++) step(1'b1, cnt);
            for (int i = 0; i < 2; i++) step(1'b0, cnt);
        end
        for (int i = 0; i < 4; i++) step(1'b1, cnt);
        for (int i = 0; i < 4; i++) step(1'b1, cnt);
        check(cnt == 4, "R7 falls at 1.0", cnt, 4);
        run = 1'b0;
    endtask

    task automatic t_latency();
        do_reset();
        src_sel = 2'd2; div_whole = 8'd1; div_sixteenths = 4'd0;
        run = 1'b1;
        repeat (3) @(negedge clk);
        b_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(strobe == 1'b0, "R9 edge k+0", strobe, 0);
        @(posedge clk); @(negedge clk);
        check(strobe == 1'b0, "R9 edge k+1", strobe, 0);
        @(posedge clk); @(negedge clk);
        check(strobe == 1'b1, "R9 edge k+2", strobe, 1);
        @(posedge clk); @(negedge clk);
        check(strobe == 1'b0, "R9 edge k+3", strobe, 0);
        run = 1'b0;
    endtask

    task automatic t_disable();
        int cnt = 0;
        int c1 = 0;
        do_reset();
        src_sel = 2'd0; div_whole = 8'd1; div_sixteenths = 4'd8;
        run = 1'b1;
        step(1'b0, cnt);
        run = 1'b0;
        for (int i = 0; i < 10; i++) step(1'b0, cnt);
        check(cnt == 0, "R8 quiet while off", cnt, 0);
        run = 1'b1;
        step(1'b0, c1);
        check(c1 == 1, "R8 remainder held", c1, 1);
        run = 1'b0;
    endtask

    initial begin
        t_reset();
        t_unity();
        t_fraction();
        t_zero_whole();
        t_level();
        t_rise();
        t_fall();
        t_latency();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule